// File: doc/BRIEF.md
# UART Receive Queue and Interrupt Identification

This block is the receive-side queue and interrupt-source logic of a 16550-style serial port. Bytes from a deserializer go into a 16-entry first-in first-out buffer. Software takes them out one at a time through a receive buffer read strobe. A single transmit holding register tracks whether the serializer can accept another byte. A one-byte status word reports data-ready, overrun, line error and transmit-holding-empty.

Three enable bits gate the interrupt sources. A prioritized identification byte names the most urgent active source, and one interrupt request line is high whenever any enabled source is active. A control write enables the queue and selects a receive threshold of 1, 4, 8 or 14 characters. The same write can also empty the receive queue or the transmit holding register. Those empty commands act as one-cycle strobes and leave no stored bit. When the queue is disabled, it holds a single character, as a character-wide port would.

Top module: `uart_rxq_ctrl`

## Requirements
- R1: After reset the status word reads 0x20 (only transmit-holding-empty set), the identification byte reads 0x01, and the interrupt request is low.
- R2: Received bytes are read back in arrival order, and up to 16 are held. Status bit 0 (data-ready) is 1 exactly while at least one byte is held.
- R3: With the queue enabled, control bits 7:6 select a receive threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. The receive-data source is active while the held count is at least the threshold and enable bit 0 is set.
- R4: A byte that arrives while the queue is full, and is not matched by a read in the same cycle, is discarded. It sets status bit 1 (overrun), which a status read clears.
- R5: Control bit 1 empties the receive queue on the next cycle, and control bit 2 empties the transmit holding register. Neither bit stays in effect, so a byte received afterwards is held normally.
- R6: Status bit 5 (transmit-holding-empty) goes to 0 on a write to the transmit holding register and goes back to 1 when the serializer takes the byte. The written byte appears on the transmit data output.
- R7: A transmit-empty condition becomes pending when the holding register goes from full to empty, or when enable bit 1 is turned on while the register is empty. It is cleared by an identification read that reports it, or by a transmit write.
- R8: The identification byte carries the source in bits 3:1: 3 for line status, 2 for receive data, 1 for transmit empty. Line status ranks first, then receive data, then transmit empty. Bit 0 is 0 when a source is active and 1 otherwise. The interrupt request is high exactly when a source is active.
- R9: A byte received with the error input high is still stored, and it sets status bit 2. That bit is cleared by a status read. Status bits 1 or 2, together with enable bit 2, make the line-status source active.
- R10: With control bit 0 clear the queue holds one byte and the threshold is 1, and identification bits 7:6 read 00. With control bit 0 set they read 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 transmit holding, 1 interrupt enable, 2 queue control |
| cfg_data | input | 8 | Write data |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Received byte had a framing or parity error |
| rbr_rd | input | 1 | Receive buffer read strobe (pops the head) |
| iir_rd | input | 1 | Identification read strobe |
| lsr_rd | input | 1 | Status read strobe |
| tx_take | input | 1 | Serializer has taken the holding byte |
| rbr_q | output | 8 | Head of the receive queue |
| tx_q | output | 8 | Transmit holding byte |
| lsr_q | output | 8 | Status word |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A corrupt occupancy count shows up at the ports one cycle later. It appears as a data-ready bit or an interrupt that disagrees with the number of bytes pushed, or as an early or late overrun at the seventeenth byte. A wrong read pointer shows up on the first read as a head byte out of arrival order. Errors in the pending transmit-empty flag or in the ranking show up in the identification byte on the cycle after the event, so the bench checks that byte after every push, read and write that can change it. It sweeps all four thresholds over every fill level from 1 to 15.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    SEL_THR = 2'd0,
    SEL_IER = 2'd1,
    SEL_FCR = 2'd2
  } cfg_sel_e;

  typedef enum logic [2:0] {
    ID_NONE = 3'd0,
    ID_THRE = 3'd1,
    ID_RXDA = 3'd2,
    ID_LINE = 3'd3
  } int_id_e;

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, pop_ok, acc;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full   = single ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
    pop_ok = pop && (cnt_q != '0);
    acc    = push && (!full || pop_ok);
    drop   = push && !acc && !clr;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (acc)    wptr_d = bump(wptr_q);
      if (pop_ok) rptr_d = bump(rptr_q);
      if (acc && !pop_ok)      cnt_d = cnt_q + CW'(1);
      else if (!acc && pop_ok) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !clr) mem[wptr_q] <= din;
  end

  assign dout  = mem[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/rxq_thr.sv
module rxq_thr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          take,
  input  logic          en_rise,
  input  logic          ack,
  output logic [DW-1:0] hold_data,
  output logic          empty,
  output logic          pend
);

  logic          hold_q, hold_d, pend_q, pend_d;
  logic [DW-1:0] data_q;

  always_comb begin
    hold_d = hold_q;
    if (clr)       hold_d = 1'b0;
    else if (wr)   hold_d = 1'b1;
    else if (take) hold_d = 1'b0;

    pend_d = pend_q;
    if (ack || (wr && !clr))             pend_d = 1'b0;
    if ((hold_q && !hold_d) || (en_rise && !hold_d)) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
      if (wr) data_q <= din;
    end
  end

  assign hold_data = data_q;
  assign empty     = !hold_q;
  assign pend      = pend_q;

endmodule

// File: rtl/rxq_intid.sv
module rxq_intid
  import uart_rxq_pkg::*;
(
  input  logic    line_act,
  input  logic    rx_act,
  input  logic    thre_act,
  output int_id_e id,
  output logic    active
);

  always_comb begin
    if (line_act)      id = ID_LINE;
    else if (rx_act)   id = ID_RXDA;
    else if (thre_act) id = ID_THRE;
    else               id = ID_NONE;
    active = line_act || rx_act || thre_act;
  end

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_data,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  input  logic          rbr_rd,
  input  logic          iir_rd,
  input  logic          lsr_rd,
  input  logic          tx_take,
  output logic [DW-1:0] rbr_q,
  output logic [DW-1:0] tx_q,
  output logic [7:0]    lsr_q,
  output logic [7:0]    iir_q,
  output logic          irq
);

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int AW  = $clog2(DEPTH);
  localparam int LV1 = 1;
  localparam int LV4 = (DEPTH < 4)  ? DEPTH : 4;
  localparam int LV8 = (DEPTH < 8)  ? DEPTH : 8;
  localparam int LVE = (DEPTH < 14) ? DEPTH : 14;

  logic [2:0]    ier_q, ier_d;
  logic          fen_q, fen_d;
  logic [1:0]    tsel_q, tsel_d;
  logic          oe_q, oe_d, le_q, le_d;
  logic          thr_wr, ier_wr, fcr_wr, rx_clr, tx_clr, ier_rise;
  logic [CW-1:0] fifo_cnt, trig_lvl;
  logic          ovf, thr_empty, thr_pend, dr, thre_ack;
  logic          line_act, rx_act, thre_act, any_act;
  int_id_e       cur_id;

  always_comb begin
    thr_wr   = cfg_wr && (cfg_sel == SEL_THR);
    ier_wr   = cfg_wr && (cfg_sel == SEL_IER);
    fcr_wr   = cfg_wr && (cfg_sel == SEL_FCR);
    rx_clr   = fcr_wr && cfg_data[1];
    tx_clr   = fcr_wr && cfg_data[2];
    ier_rise = ier_wr && cfg_data[1] && !ier_q[1];

    ier_d  = ier_wr ? cfg_data[2:0] : ier_q;
    fen_d  = fcr_wr ? cfg_data[0]   : fen_q;
    tsel_d = fcr_wr ? cfg_data[7:6] : tsel_q;

    oe_d = oe_q;
    le_d = le_q;
    if (lsr_rd) begin
      oe_d = 1'b0;
      le_d = 1'b0;
    end
    if (ovf)                            oe_d = 1'b1;
    if (rx_valid && rx_err && !rx_clr)  le_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= '0;
      fen_q  <= 1'b0;
      tsel_q <= '0;
      oe_q   <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      ier_q  <= ier_d;
      fen_q  <= fen_d;
      tsel_q <= tsel_d;
      oe_q   <= oe_d;
      le_q   <= le_d;
    end
  end

  always_comb begin
    if (!fen_q) trig_lvl = CW'(LV1);
    else begin
      case (tsel_q)
        2'd0:    trig_lvl = CW'(LV1);
        2'd1:    trig_lvl = CW'(LV4);
        2'd2:    trig_lvl = CW'(LV8);
        default: trig_lvl = CW'(LVE);
      endcase
    end
  end

  rxq_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .single(!fen_q),
    .push  (rx_valid),
    .din   (rx_data),
    .pop   (rbr_rd),
    .dout  (rbr_q),
    .count (fifo_cnt),
    .drop  (ovf)
  );

  rxq_thr #(.DW(DW)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tx_clr),
    .wr       (thr_wr),
    .din      (cfg_data[DW-1:0]),
    .take     (tx_take),
    .en_rise  (ier_rise),
    .ack      (thre_ack),
    .hold_data(tx_q),
    .empty    (thr_empty),
    .pend     (thr_pend)
  );

  assign dr       = (fifo_cnt != '0);
  assign line_act = ier_q[2] && (oe_q || le_q);
  assign rx_act   = ier_q[0] && dr && (fifo_cnt >= trig_lvl);
  assign thre_act = ier_q[1] && thr_pend;

  rxq_intid u_id (
    .line_act(line_act),
    .rx_act  (rx_act),
    .thre_act(thre_act),
    .id      (cur_id),
    .active  (any_act)
  );

  assign thre_ack = iir_rd && (cur_id == ID_THRE);
  assign irq      = any_act;
  assign iir_q    = {fen_q, fen_q, 2'b00, cur_id, !any_act};
  assign lsr_q    = {2'b00, thr_empty, 2'b00, le_q, oe_q, dr};

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [1:0]    cfg_sel,
  input logic [7:0]    cfg_data,
  input logic          rx_valid,
  input logic          rbr_rd,
  input logic          iir_rd,
  input logic [7:0]    lsr_q,
  input logic [7:0]    iir_q,
  input logic [2:0]    ier_q,
  input logic [CW-1:0] fifo_cnt
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH)); // R2

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_q[0] && !rx_valid) |=> !lsr_q[0]); // R2

  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH) && rx_valid && !rbr_rd &&
     !(cfg_wr && cfg_sel == 2'd2 && cfg_data[1])) |=> lsr_q[1]); // R4

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd2 && cfg_data[1]) |=> !lsr_q[0]); // R5

  AST_THR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd0) |=> !lsr_q[5]); // R6

  AST_THRE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_q[3:1] == 3'd1 && !cfg_wr) |=> iir_q[3:1] != 3'd1); // R7

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (lsr_q[1] || lsr_q[2])) |-> iir_q[3:1] == 3'd3); // R8

endmodule

bind uart_rxq_ctrl uart_rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_wr  (cfg_wr),
  .cfg_sel (cfg_sel),
  .cfg_data(cfg_data),
  .rx_valid(rx_valid),
  .rbr_rd  (rbr_rd),
  .iir_rd  (iir_rd),
  .lsr_q   (lsr_q),
  .iir_q   (iir_q),
  .ier_q   (ier_q),
  .fifo_cnt(fifo_cnt)
);

// File: tb/uart_rxq_ctrl_test.sv
`timescale 1ns/1ps
module uart_rxq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, rx_valid, rx_err, rbr_rd, iir_rd, lsr_rd, tx_take;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_data, rx_data;
  logic [7:0] rbr_q, tx_q, lsr_q, iir_q;
  logic       irq;
  int         nchk = 0;
  int         nfail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  uart_rxq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .rbr_rd(rbr_rd), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .tx_take(tx_take), .rbr_q(rbr_q), .tx_q(tx_q), .lsr_q(lsr_q),
    .iir_q(iir_q), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic e);
    rx_valid = 1'b1; rx_data = b; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic pop();
    rbr_rd = 1'b1;
    @(negedge clk);
    rbr_rd = 1'b0;
  endtask

  task automatic strobe_lsr();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic strobe_iir();
    iir_rd = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0;
  endtask

  task automatic take();
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_sel = 0; cfg_data = 0; rx_valid = 0;
    rx_data = 0; rx_err = 0; rbr_rd = 0; iir_rd = 0; lsr_rd = 0; tx_take = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lsr", 32'(lsr_q), 32'h20);
    chk("R1 iir", 32'(iir_q), 32'h01);
    chk("R1 irq", 32'(irq), 32'h0);

    // R10 queue disabled: one byte, threshold 1
    cfg(2'd1, 8'h01);
    push(8'hA5, 1'b0);
    chk("R10 iir rx", 32'(iir_q), 32'h04);
    chk("R10 irq", 32'(irq), 32'h1);
    push(8'h3C, 1'b0);
    chk("R10 R4 lsr overrun", 32'(lsr_q), 32'h23);
    chk("R10 head kept", 32'(rbr_q), 32'hA5);
    strobe_lsr();
    chk("R4 oe cleared", 32'(lsr_q), 32'h21);
    pop();
    chk("R2 empty after read", 32'(lsr_q), 32'h20);

    // R10 enable queue
    cfg(2'd2, 8'h07);
    chk("R10 iir enabled", 32'(iir_q), 32'hC1);

    // R3 threshold sweep
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      cfg(2'd2, 8'(s << 6) | 8'h03);
      for (int k = 1; k <= 15; k++) begin
        push(8'(k), 1'b0);
        chk($sformatf("R3 sel%0d cnt%0d irq", s, k), 32'(irq), 32'(k >= thr));
      end
    end

    // R2 / R4 full at 16, overrun at 17 (threshold 14 selected)
    push(8'd16, 1'b0);
    chk("R2 sixteen held", 32'(lsr_q), 32'h21);
    push(8'hEE, 1'b0);
    chk("R4 seventeenth dropped", 32'(lsr_q), 32'h23);
    cfg(2'd1, 8'h05);
    chk("R8 line first", 32'(iir_q), 32'hC6);
    strobe_lsr();
    chk("R8 rx after line", 32'(iir_q), 32'hC4);
    for (int i = 1; i <= 16; i++) begin
      chk($sformatf("R2 order %0d", i), 32'(rbr_q), 32'(i));
      pop();
      chk($sformatf("R3 drain irq %0d", i), 32'(irq), 32'((16 - i) >= 14));
    end
    chk("R2 drained", 32'(lsr_q), 32'h20);

    // R5 receive clear is one-shot
    push(8'h11, 1'b0); push(8'h22, 1'b0); push(8'h33, 1'b0);
    cfg(2'd2, 8'hC3);
    chk("R5 rx cleared", 32'(lsr_q[0]), 32'h0);
    push(8'h77, 1'b0);
    chk("R5 held after clear", 32'(lsr_q[0]), 32'h1);
    chk("R5 head after clear", 32'(rbr_q), 32'h77);
    pop();

    // R6 / R7 transmit holding
    cfg(2'd1, 8'h02);
    chk("R7 enable rise", 32'(iir_q), 32'hC2);
    strobe_iir();
    chk("R7 ack by id read", 32'(iir_q), 32'hC1);
    chk("R7 irq low", 32'(irq), 32'h0);
    cfg(2'd0, 8'h55);
    chk("R6 thre low", 32'(lsr_q[5]), 32'h0);
    chk("R6 tx data", 32'(tx_q), 32'h55);
    take();
    chk("R6 thre high", 32'(lsr_q[5]), 32'h1);
    chk("R7 pend on empty", 32'(iir_q), 32'hC2);
    cfg(2'd0, 8'h9A);
    chk("R7 cleared by write", 32'(iir_q), 32'hC1);
    cfg(2'd2, 8'h05);
    chk("R5 tx clear", 32'(lsr_q[5]), 32'h1);
    chk("R5 R7 pend after clear", 32'(iir_q), 32'hC2);

    // R9 / R8 line error ranking
    cfg(2'd1, 8'h07);
    push(8'h99, 1'b1);
    chk("R9 lsr err", 32'(lsr_q), 32'h25);
    chk("R9 byte stored", 32'(rbr_q), 32'h99);
    chk("R8 R9 line id", 32'(iir_q), 32'hC6);
    strobe_lsr();
    chk("R8 rx next", 32'(iir_q), 32'hC4);
    pop();
    chk("R8 thre last", 32'(iir_q), 32'hC2);
    strobe_iir();
    chk("R8 none", 32'(iir_q), 32'hC1);
    chk("R8 irq none", 32'(irq), 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule